// File: doc/BRIEF.md
# Run-Limited Pseudo-Random Slot Scheduler

This block decides, at every slot boundary, whether a beacon station should transmit or listen in the coming slot. A seedable maximal-length LFSR supplies the pseudo-random source. Its low byte is compared against a programmable threshold, so the long-run share of transmit slots tracks `dutyThr/256`. Two hard rules override the random draw. A transmit slot is always followed by a receive slot. A run of receive slots ends with a forced transmit once it reaches a programmed length. The resulting schedule looks irregular but never shows the long clusters of a plain random sequence.

The slot timer raises `slotStb` for one cycle per slot. One cycle later the block presents the decision on `txOut` and pulses `validOut`. Software-style configuration is carried on plain inputs: a seed word with a load pulse, the duty threshold and the receive-run cap.

Top module: `slot_sched`

## Requirements
- R1: The LFSR is Fibonacci-style. On each step all bits shift one place up and bit 0 takes the XOR of the tap bits. For the default 32-bit width the tap bits are 31, 21, 1 and 0. Widths of 16, 32, 64, 128 and 256 bits are supported. The state advances exactly once per `slotStb`.
- R2: A `seedLoad` pulse copies `seedIn` into the LFSR. An all-zero seed is replaced by the value 1. After reset the state is 1.
- R3: A slot never carries a transmit decision (`txOut`=1) when the previous slot carried one.
- R4: Unless R3 or R5 forces the outcome, a slot transmits exactly when bits [7:0] of the LFSR state, taken before that strobe's advance, are below `dutyThr`. With `dutyThr`=0, only R5 can force a transmit.
- R5: The block counts receive slots since the last transmit, or since reset. This counter saturates at all ones. At a strobe, if the previous slot was not a transmit and the counter is at or above `maxRxRun`, the slot transmits. R3 takes precedence over this rule.
- R6: `txOut` and `validOut` are registered and both are 0 after reset. `validOut` is high for exactly the one cycle after each strobe, and `txOut` changes only in that cycle.
- R7: When `seedLoad` and `slotStb` arrive in the same cycle, the decision uses the effective loaded seed as the state. The state then becomes one step past that seed.
- R8: A `seedLoad` without a strobe produces no decision. It leaves `txOut`, the receive-run count and the previous-transmit memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStb | input | 1 | One-cycle pulse at each slot boundary |
| seedIn | input | LFSR_W | Seed word |
| seedLoad | input | 1 | Load `seedIn` into the LFSR |
| dutyThr | input | 8 | Transmit threshold on the LFSR low byte |
| maxRxRun | input | RUN_W | Longest allowed run of receive slots |
| txOut | output | 1 | 1 = transmit, 0 = receive for the slot |
| validOut | output | 1 | One-cycle pulse marking a new decision |

## Verification
Two collisions can happen in a single cycle.

The first is a seed load arriving on the same edge as a slot strobe. The bench drives both pulses together, using a seed whose low byte sits under the threshold. It then expects the decision to come from that seed, and the following slots to continue one LFSR step past it. It also issues a bare load right after a transmit slot, and expects the next strobe to still be forced to receive.

The second collision is between the two override rules. With `maxRxRun`=0, the receive cap and the no-transmit-pair rule both apply on every slot after a transmit. The scoreboard expects a strict transmit/receive alternation.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } ctrlStb_t;

  function automatic logic [255:0] tapMask(input int w);
    logic [255:0] m;
    m = '0;
    case (w)
      16:  begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
      32:  begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
      64:  begin m[63] = 1'b1; m[62] = 1'b1; m[60] = 1'b1; m[59] = 1'b1; end
      128: begin m[127] = 1'b1; m[125] = 1'b1; m[100] = 1'b1; m[98] = 1'b1; end
      256: begin m[255] = 1'b1; m[253] = 1'b1; m[250] = 1'b1; m[245] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic bit widthOk(input int w);
    return (w == 16) || (w == 32) || (w == 64) || (w == 128) || (w == 256);
  endfunction

endpackage

// File: rtl/slot_lfsr_dp.sv
module slot_lfsr_dp
  import slot_sched_pkg::*;
#(
  parameter int LFSR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [LFSR_W-1:0] seedIn,
  input  logic [7:0]        dutyThr,
  output logic              txReq,
  output logic [LFSR_W-1:0] stateOut
);
  localparam logic [255:0]        FULL_MASK = tapMask(LFSR_W);
  localparam logic [LFSR_W-1:0]   TAP_MASK  = FULL_MASK[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0]   DEF_SEED  = LFSR_W'(1);

  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] effSeed;
  logic [LFSR_W-1:0] cur;
  logic [LFSR_W-1:0] stepped;
  logic              feedback;

  always_comb begin
    effSeed  = (seedIn == '0) ? DEF_SEED : seedIn;
    cur      = stb.loadSeed ? effSeed : state;
    feedback = ^(cur & TAP_MASK);
    stepped  = {cur[LFSR_W-2:0], feedback};
    txReq    = cur[7:0] < dutyThr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= DEF_SEED;
    end else if (stb.advance) begin
      state <= stepped;
    end else if (stb.loadSeed) begin
      state <= effSeed;
    end
  end

  assign stateOut = state;
endmodule

// File: rtl/slot_sched_ctrl.sv
module slot_sched_ctrl
  import slot_sched_pkg::*;
#(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotStb,
  input  logic             seedLoad,
  input  logic [RUN_W-1:0] maxRxRun,
  input  logic             txReq,
  output ctrlStb_t         stb,
  output logic             txOut,
  output logic             validOut
);
  localparam logic [RUN_W-1:0] RUN_SAT = '1;

  logic [RUN_W-1:0] rxRun;
  logic             prevTx;
  logic             decision;

  always_comb begin
    stb.loadSeed = seedLoad;
    stb.advance  = slotStb;
    if (prevTx) begin
      decision = 1'b0;
    end else if (rxRun >= maxRxRun) begin
      decision = 1'b1;
    end else begin
      decision = txReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxRun    <= '0;
      prevTx   <= 1'b0;
      txOut    <= 1'b0;
      validOut <= 1'b0;
    end else begin
      validOut <= slotStb;
      if (slotStb) begin
        txOut  <= decision;
        prevTx <= decision;
        if (decision) begin
          rxRun <= '0;
        end else if (rxRun != RUN_SAT) begin
          rxRun <= rxRun + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int LFSR_W = 32,
  parameter int RUN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStb,
  input  logic [LFSR_W-1:0] seedIn,
  input  logic              seedLoad,
  input  logic [7:0]        dutyThr,
  input  logic [RUN_W-1:0]  maxRxRun,
  output logic              txOut,
  output logic              validOut
);
  generate
    if (!widthOk(LFSR_W)) begin : gBadWidth
      $error("slot_sched: unsupported LFSR_W");
    end
  endgenerate

  ctrlStb_t          stb;
  logic              txReq;
  logic [LFSR_W-1:0] lfsrState;

  slot_sched_ctrl #(.RUN_W(RUN_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotStb  (slotStb),
    .seedLoad (seedLoad),
    .maxRxRun (maxRxRun),
    .txReq    (txReq),
    .stb      (stb),
    .txOut    (txOut),
    .validOut (validOut)
  );

  slot_lfsr_dp #(.LFSR_W(LFSR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .seedIn   (seedIn),
    .dutyThr  (dutyThr),
    .txReq    (txReq),
    .stateOut (lfsrState)
  );
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int LFSR_W = 32,
  parameter int RUN_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotStb,
  input logic [7:0]        dutyThr,
  input logic [RUN_W-1:0]  maxRxRun,
  input logic              txOut,
  input logic              validOut,
  input logic [LFSR_W-1:0] lfsrState
);
  localparam logic [RUN_W-1:0] SAT = '1;

  logic             lastTx;
  logic [RUN_W-1:0] chkRx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastTx <= 1'b0;
      chkRx  <= '0;
    end else if (validOut) begin
      lastTx <= txOut;
      if (txOut) chkRx <= '0;
      else if (chkRx != SAT) chkRx <= chkRx + 1'b1;
    end
  end

  AST_NO_TX_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    validOut && txOut |-> !lastTx); // R3

  AST_RX_RUN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    validOut && !txOut && !lastTx |-> chkRx < $past(maxRxRun)); // R5

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    validOut && ($past(dutyThr) == 8'd0) && !lastTx && (chkRx < $past(maxRxRun)) |-> !txOut); // R4

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    slotStb |=> validOut); // R6

  AST_VALID_ONLY_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> $past(slotStb)); // R6

  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !validOut && $past(rstN) |-> $stable(txOut)); // R6

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0); // R2
endmodule

bind slot_sched slot_sched_chk #(.LFSR_W(LFSR_W), .RUN_W(RUN_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .slotStb   (slotStb),
  .dutyThr   (dutyThr),
  .maxRxRun  (maxRxRun),
  .txOut     (txOut),
  .validOut  (validOut),
  .lfsrState (lfsrState)
);

// File: tb/tb_slot_sched.sv
module tb_slot_sched;
  localparam int LFSR_W = 32;
  localparam int RUN_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              slotStb = 1'b0;
  logic [LFSR_W-1:0] seedIn = '0;
  logic              seedLoad = 1'b0;
  logic [7:0]        dutyThr = 8'd0;
  logic [RUN_W-1:0]  maxRxRun = '0;
  logic              txOut;
  logic              validOut;

  always #2.5 clk = ~clk;

  slot_sched #(.LFSR_W(LFSR_W), .RUN_W(RUN_W)) dut (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .seedIn(seedIn),
    .seedLoad(seedLoad), .dutyThr(dutyThr), .maxRxRun(maxRxRun),
    .txOut(txOut), .validOut(validOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [LFSR_W-1:0] mState = 32'd1;
  logic              mPrevTx = 1'b0;
  logic [RUN_W-1:0]  mRx = '0;
  logic              lastObsTx = 1'b0;

  typedef struct { logic tx; string tag; } exp_t;
  exp_t expQ[$];

  function automatic logic [LFSR_W-1:0] stepM(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: one slot, optionally with a seed load in the same cycle
  task automatic doSlot(input logic [7:0] thr, input logic [RUN_W-1:0] mx,
                        input bit ld, input logic [LFSR_W-1:0] sd, input string tag);
    logic [LFSR_W-1:0] cur;
    exp_t e;
    dutyThr  = thr;
    maxRxRun = mx;
    slotStb  = 1'b1;
    seedLoad = ld;
    seedIn   = sd;
    cur = ld ? ((sd == '0) ? 32'd1 : sd) : mState;
    if (mPrevTx) e.tx = 1'b0;
    else if (mRx >= mx) e.tx = 1'b1;
    else e.tx = (cur[7:0] < thr);
    e.tag = tag;
    expQ.push_back(e);
    mState  = stepM(cur);
    mPrevTx = e.tx;
    if (e.tx) mRx = '0;
    else if (mRx != '1) mRx = mRx + 1'b1;
    @(negedge clk);
    slotStb  = 1'b0;
    seedLoad = 1'b0;
  endtask

  task automatic loadOnly(input logic [LFSR_W-1:0] sd);
    seedIn   = sd;
    seedLoad = 1'b1;
    mState   = (sd == '0) ? 32'd1 : sd;
    @(negedge clk);
    seedLoad = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && validOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(txOut === e.tx, e.tag, int'(txOut), int'(e.tx));
        check(!(txOut && lastObsTx), "R3 tx pair", int'(txOut), 0);
        lastObsTx = txOut;
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic holdTx;
    gap(3);
    check(validOut === 1'b0 && txOut === 1'b0, "R6 reset outputs", int'(validOut), 0);
    rstN = 1'b1;
    gap(2);

    // plain run from the reset state (R1, R4)
    for (int i = 0; i < 30; i++) begin doSlot(8'd85, 4'd3, 0, '0, "R4 reset-seed run"); gap(i % 3); end

    // seed load alone (R2, R8): no decision, output held
    holdTx = txOut;
    loadOnly(32'hACE1_2345);
    gap(3);
    check(validOut === 1'b0 && txOut === holdTx, "R8 load without strobe", int'(txOut), int'(holdTx));
    for (int i = 0; i < 40; i++) begin doSlot(8'd85, 4'd3, 0, '0, "R1 seeded sequence"); gap(1); end

    // threshold zero: only forced transmits (R5)
    for (int i = 0; i < 20; i++) doSlot(8'd0, 4'd4, 0, '0, "R5 cap forces tx");
    // threshold max: alternation (R3)
    for (int i = 0; i < 20; i++) doSlot(8'd255, 4'd7, 0, '0, "R3 forced rx after tx");
    // maxRxRun zero: both overrides collide (R3, R5)
    for (int i = 0; i < 12; i++) doSlot(8'd0, 4'd0, 0, '0, "R5 zero cap alternation");

    // zero seed replaced by 1 (R2)
    loadOnly('0);
    gap(1);
    for (int i = 0; i < 10; i++) doSlot(8'd60, 4'd5, 0, '0, "R2 zero seed default");

    // load and strobe together after a receive slot (R7)
    while (mPrevTx) doSlot(8'd0, 4'd9, 0, '0, "R7 settle");
    doSlot(8'd10, 4'd9, 1, 32'h1234_5600, "R7 load with strobe");
    for (int i = 0; i < 15; i++) doSlot(8'd100, 4'd4, 0, '0, "R7 continue after load");

    // bare load right after a transmit keeps forced rx (R8)
    while (!mPrevTx) doSlot(8'd0, 4'd2, 0, '0, "R8 settle");
    loadOnly(32'h0000_0001);
    gap(2);
    doSlot(8'd255, 4'd2, 0, '0, "R8 prev tx kept over load");
    for (int i = 0; i < 10; i++) doSlot(8'd200, 4'd2, 0, '0, "R4 after R8");

    gap(3);
    check(expQ.size() == 0, "R6 all decisions seen", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule